// File: doc/BRIEF.md
# Ping-Pong Cache with Narrow Write and Wide Read

This block holds two equal cache banks that take turns. One bank is the write target. A producer fills it one 64-bit word at a time through a 10-bit address. The other bank is the read source. A consumer fetches it four words at a time through an 8-bit address and a 256-bit data port. The consumer is typically an external-memory controller doing burst transfers.

The producer ends a frame with a single strobe, sent once its last entries (such as per-page terminators) are stored. On that edge the two banks trade roles. After a fixed, parameterised number of cycles, the bank that was just filled raises its own ready flag. The flag stays up until a later frame end makes that bank the write target again. Both ports run on one clock.

Top module: `pingpong_width_cache`

## Requirements
- R1: After reset, bank 0 is the write target, bank 1 is the read source, both `bankValid` outputs are low and `rdData` is zero.
- R2: When `wrEn` is high at a clock edge, `wrData` is stored at `wrAddr` of the bank that is the write target at that edge.
- R3: Read word k is built from write locations 4k, 4k+1, 4k+2 and 4k+3. Location 4k sits in bits 63:0, 4k+1 in bits 127:64, 4k+2 in bits 191:128 and 4k+3 in bits 255:192.
- R4: When `rdEn` is high at an edge, the addressed word is on `rdData` after that edge. When `rdEn` is low, `rdData` holds its last value.
- R5: Reads always come from the bank that is not the write target at the sampling edge.
- R6: A high `frameEnd` at an edge swaps the two roles at that edge. A write or read taken on that same edge still uses the roles from before the swap. Without `frameEnd`, the roles never change.
- R7: The ready flag of the bank just filled rises exactly VALID_DELAY edges after the edge that sampled `frameEnd` (default 4). `bankValid0` belongs to bank 0 and `bankValid1` to bank 1.
- R8: A bank's ready flag is low from the `frameEnd` edge that makes it the write target again. A ready flag still pending for that bank is dropped and never appears.
- R9: Writes never change the contents of the bank that is currently the read source.
- R10: At most one of the two ready flags is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the write-target bank |
| wrAddr | input | 10 | Narrow-word write address |
| wrData | input | 64 | Narrow write word |
| frameEnd | input | 1 | One-cycle end-of-frame strobe that swaps the banks |
| rdEn | input | 1 | Read strobe for the read-source bank |
| rdAddr | input | 8 | Wide-word read address |
| rdData | output | 256 | Registered wide read word |
| bankValid0 | output | 1 | Bank 0 holds a complete frame ready to read |
| bankValid1 | output | 1 | Bank 1 holds a complete frame ready to read |

## Verification
Suppose the role bit is inverted or stuck. Then the next read after a frame end returns the bank being filled, so `rdData` differs from the model one cycle after the first `rdEn`. It does so in all four lanes unless the bank contents happen to agree. A miscounted ready delay shows on `bankValid0/1` within VALID_DELAY cycles of the strobe. A pending flag that is not cancelled shows as both flags high, or as a flag on the bank being written. Swapped lanes or a wrong address split corrupt every read word at the slice that moved.

// File: rtl/pp_cache_pkg.sv
package pp_cache_pkg;
  // Strobes from the control side to the storage side.
  typedef struct packed {
    logic       wrBank;    // bank currently written
    logic       rdBank;    // bank currently read
    logic [1:0] wrMask;    // one-hot write strobe per bank
    logic       rdStrobe;  // capture a wide word this edge
  } cacheStrobes_t;
endpackage

// File: rtl/pp_cache_ctrl.sv
module pp_cache_ctrl
  import pp_cache_pkg::*;
#(
  parameter int VALID_DELAY = 4   // must be at least 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic          frameEnd,
  output cacheStrobes_t strobes,
  output logic [1:0]    validQ
);
  localparam int CNT_W = $clog2(VALID_DELAY + 1);

  logic             writeSel;
  logic             pendBank;
  logic [CNT_W-1:0] delayCnt;
  logic [1:0]       validNext;

  always_comb begin
    strobes.wrBank   = writeSel;
    strobes.rdBank   = ~writeSel;
    strobes.wrMask   = wrEn ? (2'b01 << writeSel) : 2'b00;
    strobes.rdStrobe = rdEn;
  end

  // A pending flag is set first; a frame end that retargets the bank
  // clears it afterwards, so the clear wins.
  always_comb begin
    validNext = validQ;
    if (delayCnt == CNT_W'(1)) validNext[pendBank] = 1'b1;
    if (frameEnd)              validNext[~writeSel] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      writeSel <= 1'b0;
      pendBank <= 1'b0;
      delayCnt <= '0;
      validQ   <= 2'b00;
    end else begin
      validQ <= validNext;
      if (frameEnd) begin
        writeSel <= ~writeSel;
        pendBank <= writeSel;
        delayCnt <= CNT_W'(VALID_DELAY);
      end else if (delayCnt != '0) begin
        delayCnt <= delayCnt - CNT_W'(1);
      end
    end
  end

  AST_ROLE_SWAP: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> (writeSel != $past(writeSel)));  // R6
  AST_ROLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !frameEnd |=> $stable(writeSel));  // R6
  AST_NO_VALID_ON_WRITE_BANK: assert property (@(posedge clk) disable iff (!rstN)
    validQ[writeSel] == 1'b0);  // R8
  AST_ONE_VALID: assert property (@(posedge clk) disable iff (!rstN)
    $countones(validQ) <= 1);  // R10
endmodule

// File: rtl/pp_cache_datapath.sv
module pp_cache_datapath
  import pp_cache_pkg::*;
#(
  parameter int WR_ADDR_W  = 10,
  parameter int DATA_W     = 64,
  parameter int RATIO_LOG2 = 2
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  cacheStrobes_t                         strobes,
  input  logic [WR_ADDR_W-1:0]                  wrAddr,
  input  logic [DATA_W-1:0]                     wrData,
  input  logic [WR_ADDR_W-RATIO_LOG2-1:0]       rdAddr,
  output logic [(DATA_W<<RATIO_LOG2)-1:0]       rdData
);
  localparam int RATIO = 1 << RATIO_LOG2;
  localparam int DEPTH = 1 << WR_ADDR_W;
  localparam int RD_W  = DATA_W * RATIO;

  for (genvar b = 0; b < 2; b++) begin : gBank
    logic [DATA_W-1:0] mem [DEPTH];
    logic [RD_W-1:0]   word;

    always_ff @(posedge clk) begin
      if (strobes.wrMask[b]) mem[wrAddr] <= wrData;
    end

    // Lane l of the wide word is narrow location {rdAddr, l}.
    for (genvar l = 0; l < RATIO; l++) begin : gLane
      assign word[l*DATA_W +: DATA_W] = mem[{rdAddr, RATIO_LOG2'(l)}];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 rdData <= '0;
    else if (strobes.rdStrobe) rdData <= strobes.rdBank ? gBank[1].word : gBank[0].word;
  end

  AST_WRITE_ONE_BANK: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.wrMask));  // R2
  AST_NO_WRITE_TO_READ_BANK: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrMask[strobes.rdBank] == 1'b0);  // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rdStrobe |=> $stable(rdData));  // R4
endmodule

// File: rtl/pingpong_width_cache.sv
module pingpong_width_cache
  import pp_cache_pkg::*;
#(
  parameter int WR_ADDR_W   = 10,
  parameter int DATA_W      = 64,
  parameter int RATIO_LOG2  = 2,
  parameter int VALID_DELAY = 4,
  localparam int RD_ADDR_W  = WR_ADDR_W - RATIO_LOG2,
  localparam int RD_W       = DATA_W << RATIO_LOG2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [WR_ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0]    wrData,
  input  logic                 frameEnd,
  input  logic                 rdEn,
  input  logic [RD_ADDR_W-1:0] rdAddr,
  output logic [RD_W-1:0]      rdData,
  output logic                 bankValid0,
  output logic                 bankValid1
);
  cacheStrobes_t strobes;
  logic [1:0]    validQ;

  pp_cache_ctrl #(.VALID_DELAY(VALID_DELAY)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
    .frameEnd(frameEnd), .strobes(strobes), .validQ(validQ)
  );

  pp_cache_datapath #(
    .WR_ADDR_W(WR_ADDR_W), .DATA_W(DATA_W), .RATIO_LOG2(RATIO_LOG2)
  ) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData)
  );

  assign bankValid0 = validQ[0];
  assign bankValid1 = validQ[1];
endmodule

// File: tb/tb_pingpong_width_cache.sv
module tb_pingpong_width_cache;
  localparam int DELAY = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic [9:0]   wrAddr = '0;
  logic [63:0]  wrData = '0;
  logic         frameEnd = 1'b0;
  logic         rdEn = 1'b0;
  logic [7:0]   rdAddr = '0;
  logic [255:0] rdData;
  logic         bankValid0, bankValid1;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  // reference model state
  logic [63:0]  refMem [2][1024];
  logic         refWr = 1'b0;
  logic         refPend = 1'b0;
  int           refCnt = 0;
  logic [1:0]   refValid = 2'b00;
  logic [255:0] refRd = '0;

  pingpong_width_cache #(.VALID_DELAY(DELAY)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .frameEnd(frameEnd), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .bankValid0(bankValid0), .bankValid1(bankValid1)
  );

  always #5 clk = ~clk;

  function automatic logic [63:0] pat(input int f, input int a);
    logic [31:0] h;
    h = 32'(a) * 32'h9E3779B1 + 32'(f);
    return {8'(f), 24'h5A5A00 ^ 24'(a), h};
  endfunction

  task automatic check1(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // model: updated on every edge from the inputs sampled there
  always @(posedge clk) begin
    if (!rstN) begin
      refWr = 1'b0; refPend = 1'b0; refCnt = 0; refValid = 2'b00; refRd = '0;
    end else begin
      if (rdEn)
        for (int i = 0; i < 4; i++)
          refRd[i*64 +: 64] = refMem[!refWr][{rdAddr, 2'(i)}];
      if (wrEn) refMem[refWr][wrAddr] = wrData;
      if (refCnt == 1) refValid[refPend] = 1'b1;
      if (refCnt != 0) refCnt--;
      if (frameEnd) begin
        refValid[!refWr] = 1'b0;
        refPend = refWr;
        refCnt  = DELAY;
        refWr   = !refWr;
      end
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      check1("R2/R3/R4/R5/R9 rdData", rdData, refRd);
      check1("R7/R8/R10 bankValid0", 256'(bankValid0), 256'(refValid[0]));
      check1("R7/R8/R10 bankValid1", 256'(bankValid1), 256'(refValid[1]));
    end
  end

  task automatic fillFrame(input int f, input bit doRead);
    for (int a = 0; a < 1024; a++) begin
      @(negedge clk);
      wrEn = 1'b1; wrAddr = 10'(a); wrData = pat(f, a);
      rdEn = doRead && a[0]; rdAddr = 8'((a * 37) % 256);
    end
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
  endtask

  // frame end with a same-edge write and read (R6), then delay check (R7)
  task automatic endFrame(input int f, input bit checkDelay);
    logic filled;
    filled = refWr;
    @(negedge clk);
    frameEnd = 1'b1;
    wrEn = 1'b1; wrAddr = 10'd0; wrData = pat(f + 100, 0);
    rdEn = 1'b1; rdAddr = 8'd0;
    @(negedge clk);
    frameEnd = 1'b0; wrEn = 1'b0; rdEn = 1'b0;
    check1("R8 flag of new write bank low", 256'(filled ? bankValid0 : bankValid1), 256'(0));
    if (checkDelay) begin
      for (int k = 0; k < DELAY; k++) begin
        check1("R7 flag not early", 256'(filled ? bankValid1 : bankValid0), 256'(0));
        @(negedge clk);
      end
      check1("R7 flag at delay", 256'(filled ? bankValid1 : bankValid0), 256'(1));
    end
  endtask

  initial begin
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < 1024; a++) refMem[b][a] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check1("R1 rdData zero", rdData, '0);
    check1("R1 flags low", 256'({bankValid1, bankValid0}), 256'(0));

    fillFrame(1, 1'b0);        // bank 0 filled
    endFrame(1, 1'b1);
    fillFrame(2, 1'b1);        // bank 1 filled, bank 0 read
    endFrame(2, 1'b1);
    fillFrame(3, 1'b1);
    endFrame(3, 1'b0);
    repeat (2) @(negedge clk); // second end before delay expires: R8 cancel
    endFrame(4, 1'b1);
    fillFrame(5, 1'b1);
    endFrame(5, 1'b1);
    // R3 explicit lane order on bank just filled (frame 5 data, word 1)
    @(negedge clk);
    rdEn = 1'b1; rdAddr = 8'd1;
    @(negedge clk);
    rdEn = 1'b0;
    check1("R3 lane order", rdData, {pat(5, 7), pat(5, 6), pat(5, 5), pat(5, 4)});
    // R4 hold while idle
    repeat (3) @(negedge clk);
    check1("R4 hold", rdData, {pat(5, 7), pat(5, 6), pat(5, 5), pat(5, 4)});
    // R9 writes while reading must not disturb read bank
    fillFrame(6, 1'b1);
    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<200000 cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule